// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two 16-bit unsigned operands over many clock cycles and returns the full 32-bit product. It spends a few registers and a single adder on the job instead of a full array multiplier. The caller waits until `done_o` is high, presents the operands and raises `start_i`. The caller then waits for `done_o` to rise again and reads `product_o`, which holds the result until the next operation completes.

The multiplier operand is scanned from its most significant bit downwards. For each bit the accumulator receives the multiplicand when that bit is set. Between bits the accumulator and the multiplier register both move one place to the left. A seven-state controller sequences the datapath. It keeps exactly one flip-flop per state, and each state's next value is the OR of the transitions that enter it. The controller reads only two condition bits: the top bit of the multiplier register and the top bit of a 5-bit iteration counter.

Top module: `mul_seq_top`

## Requirements
- R1: A rising clock edge with `rst_n` low returns the block to idle with `done_o` = 1 and `product_o` = 0.
- R2: While idle with `start_i` low, the block stays idle, `done_o` stays 1 and `product_o` does not change, whatever the operand inputs do.
- R3: A high `start_i` sampled at a rising edge while idle captures both operands. `done_o` falls at the next rising edge and stays low until the operation completes.
- R4: On completion, `product_o` equals the unsigned product `multiplicand_i` × `multiplier_i` of the captured operands, all 32 bits. This holds at the extremes 0, 1 and 0xFFFF.
- R5: `done_o` returns to 1 exactly 49 + N rising edges after the edge that sampled `start_i`, where N is the number of set bits in the captured multiplier. An add cycle is spent only for a set bit.
- R6: While an operation is in progress, `start_i` and the operand inputs are ignored. Neither the result nor the completion time changes.
- R7: `product_o` changes only at the edge where `done_o` rises, and otherwise holds its value.
- R8: The controller always has exactly one state flip-flop set, so the cycle sequence in R5 is deterministic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled only while idle) |
| multiplicand_i | input | 16 | Unsigned multiplicand |
| multiplier_i | input | 16 | Unsigned multiplier, scanned MSB first |
| product_o | output | 32 | Registered product, held between completions |
| done_o | output | 1 | High when idle and ready; low while busy |

## Verification
The bench runs a cycle-accurate behavioural model that predicts `done_o` and `product_o` on every clock. A design that skipped the final shift, or shifted once too often, would return a product off by a factor of two. Multipliers of 0 and 0xFFFF give the shortest and longest operations, so an add state entered on a clear bit, or a missed add, shows up as a completion at the wrong edge. The 0xFFFF × 0xFFFF case exposes an accumulator that drops its top carry. Start pulses and operand changes in the middle of an operation catch a controller that re-enters the load state or a datapath that re-samples its inputs. Idle cycles with moving operands catch a product register that is not properly held.

// File: rtl/mul_seq_pkg.sv
// Package: shared state indices and datapath control bundle for the
// sequential multiplier. Assumes the controller is one-hot.
package mul_seq_pkg;
    localparam int ST_IDLE  = 0;
    localparam int ST_LOAD  = 1;
    localparam int ST_TEST  = 2;
    localparam int ST_ADD   = 3;
    localparam int ST_CHECK = 4;
    localparam int ST_SHIFT = 5;
    localparam int ST_OUT   = 6;
    localparam int ST_COUNT = 7;

    typedef logic [ST_COUNT-1:0] onehot_t;

    typedef struct packed {
        logic load;     // capture operands, clear accumulator and counter
        logic test;     // bump iteration counter
        logic add;      // accumulator += multiplicand
        logic shift;    // shift accumulator and multiplier left
        logic capture;  // copy accumulator to product output
    } dp_ctrl_t;
endpackage

// File: rtl/mul_seq_ctrl.sv
// Controller: one flip-flop per state, next value is the OR of incoming arcs.
// Assumes synchronous active-low reset; start only honoured in idle.
module mul_seq_ctrl
    import mul_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     bit_msb_i,
    input  logic     iter_top_i,
    output dp_ctrl_t ctl_o,
    output logic     done_o
);
    onehot_t st_q;
    onehot_t st_d;
    logic    done_q;

    // Next-state logic: each flip-flop collects its inward transitions.
    always_comb begin
        st_d           = '0;
        st_d[ST_IDLE]  = (st_q[ST_IDLE] & ~start_i) | st_q[ST_OUT];
        st_d[ST_LOAD]  = st_q[ST_IDLE] & start_i;
        st_d[ST_TEST]  = st_q[ST_LOAD] | st_q[ST_SHIFT];
        st_d[ST_ADD]   = st_q[ST_TEST] & bit_msb_i;
        st_d[ST_CHECK] = (st_q[ST_TEST] & ~bit_msb_i) | st_q[ST_ADD];
        st_d[ST_SHIFT] = st_q[ST_CHECK] & ~iter_top_i;
        st_d[ST_OUT]   = st_q[ST_CHECK] & iter_top_i;
    end

    // State register: reset sets only the idle flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= onehot_t'(1) << ST_IDLE;
        else        st_q <= st_d;
    end

    // Done flag: cleared on load, set on output.
    always_ff @(posedge clk) begin
        if (!rst_n)               done_q <= 1'b1;
        else if (st_q[ST_LOAD])   done_q <= 1'b0;
        else if (st_q[ST_OUT])    done_q <= 1'b1;
    end

    // Control strobes decoded from single state bits.
    always_comb begin
        ctl_o.load    = st_q[ST_LOAD];
        ctl_o.test    = st_q[ST_TEST];
        ctl_o.add     = st_q[ST_ADD];
        ctl_o.shift   = st_q[ST_SHIFT];
        ctl_o.capture = st_q[ST_OUT];
    end

    assign done_o = done_q;

    AST_ONE_HOT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[ST_IDLE] && !start_i) |=> (st_q[ST_IDLE] && done_o)); // R2
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[ST_LOAD] |=> !done_o); // R3
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q[ST_IDLE] |=> !st_q[ST_LOAD]); // R6
endmodule

// File: rtl/mul_seq_datapath.sv
// Datapath: multiplicand register, left-shifting multiplier register,
// left-shifting double-width accumulator, iteration counter, product register.
// Assumes W is a power of two so the counter's top bit marks W iterations.
module mul_seq_datapath
    import mul_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  dp_ctrl_t       ctl_i,
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic           bit_msb_o,
    output logic           iter_top_o,
    output logic [2*W-1:0] z_o
);
    localparam int PW    = 2 * W;
    localparam int CNT_W = $clog2(W) + 1;

    logic [W-1:0]     a_q;
    logic [W-1:0]     b_q;
    logic [PW-1:0]    m_q;
    logic [PW-1:0]    m_sel;
    logic [W-1:0]     b_sel;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    z_q;

    // Two-way selectors feeding the accumulator and multiplier registers.
    assign m_sel = ctl_i.add  ? (m_q + {{W{1'b0}}, a_q}) : {m_q[PW-2:0], 1'b0};
    assign b_sel = ctl_i.load ? y_i : {b_q[W-2:0], 1'b0};

    // Multiplicand register: loaded once per operation.
    always_ff @(posedge clk) begin
        if (!rst_n)          a_q <= '0;
        else if (ctl_i.load) a_q <= x_i;
    end

    // Multiplier register: load or shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)                         b_q <= '0;
        else if (ctl_i.load || ctl_i.shift) b_q <= b_sel;
    end

    // Accumulator: clear, add or shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)                        m_q <= '0;
        else if (ctl_i.load)               m_q <= '0;
        else if (ctl_i.add || ctl_i.shift) m_q <= m_sel;
    end

    // Iteration counter: clear on load, count each bit test.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (ctl_i.load) cnt_q <= '0;
        else if (ctl_i.test) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Product register: holds until the next completion.
    always_ff @(posedge clk) begin
        if (!rst_n)             z_q <= '0;
        else if (ctl_i.capture) z_q <= m_q;
    end

    assign bit_msb_o  = b_q[W-1];
    assign iter_top_o = cnt_q[CNT_W-1];
    assign z_o        = z_q;

    AST_ADD_ON_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.add |-> b_q[W-1]); // R5
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(W)); // R5
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_i.capture |=> $stable(z_q)); // R7
    AST_ADD_NO_CARRY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.add |=> (m_q >= {{W{1'b0}}, a_q})); // R4
endmodule

// File: rtl/mul_seq_top.sv
// Top: 16x16 unsigned sequential multiplier, MSB-first shift-add.
// Assumes caller waits for done_o high before a new start.
module mul_seq_top
    import mul_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   multiplicand_i,
    input  logic [W-1:0]   multiplier_i,
    output logic [2*W-1:0] product_o,
    output logic           done_o
);
    dp_ctrl_t ctl;
    logic     bit_msb;
    logic     iter_top;

    mul_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bit_msb_i  (bit_msb),
        .iter_top_i (iter_top),
        .ctl_o      (ctl),
        .done_o     (done_o)
    );

    mul_seq_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (ctl),
        .x_i        (multiplicand_i),
        .y_i        (multiplier_i),
        .bit_msb_o  (bit_msb),
        .iter_top_o (iter_top),
        .z_o        (product_o)
    );

    AST_PRODUCT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product_o) |-> $rose(done_o)); // R7
endmodule

// File: tb/mul_seq_top_bench.sv
module mul_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] xin = '0;
    logic [15:0] yin = '0;
    logic [31:0] prod;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference model state
    bit          mdl_valid = 0;
    int          mdl_rem = 0;
    bit          mdl_done = 1;
    logic [31:0] mdl_z = '0;
    logic [31:0] mdl_pend = '0;

    always #2 clk = ~clk; // 250 MHz

    mul_seq_top u_mul_seq_top (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .multiplicand_i(xin), .multiplier_i(yin),
        .product_o(prod), .done_o(done)
    );

    // Reference model: predicts outputs after each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            mdl_valid = 1; mdl_rem = 0; mdl_done = 1; mdl_z = '0;
        end else if (mdl_rem == 0) begin
            if (start) begin
                mdl_rem  = 49 + $countones(yin);
                mdl_pend = {16'h0, xin} * {16'h0, yin};
            end
        end else begin
            mdl_rem--;
            if (mdl_rem == 0) begin mdl_done = 1; mdl_z = mdl_pend; end
            else mdl_done = 0;
        end
    end

    // Per-cycle comparison away from the active edge (R1 R2 R3 R6 R7 R8).
    always @(negedge clk) begin
        if (mdl_valid) begin
            checks++;
            if (done !== mdl_done || prod !== mdl_z) begin
                fails++;
                $display("FAIL R3,R7,R8 cycle %0d: done=%b prod=%h expected done=%b prod=%h",
                         cycles, done, prod, mdl_done, mdl_z);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation, optionally disturbed mid-run; checks product and latency.
    task automatic run_op(input logic [15:0] x, input logic [15:0] y, input bit disturb);
        int n = 0;
        logic [31:0] exp = {16'h0, x} * {16'h0, y};
        int lat = 49 + $countones(y);
        @(negedge clk); xin = x; yin = y; start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1;
        forever begin
            if (disturb && n == 10) begin start = 1'b1; xin = ~x; yin = ~y; end
            if (disturb && n == 14) begin start = 1'b0; end
            @(negedge clk); n++;
            if (done === 1'b1 && n > 2) break;
            if (n > 200) break;
        end
        start = 1'b0;
        check(prod === exp, disturb ? "R6 product with busy start" : "R4 product", prod, exp);
        check((n - 1) == lat, "R5 latency", 32'(n - 1), 32'(lat));
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b1, "R1 done after reset", 32'(done), 32'd1);
        check(prod === 32'h0, "R1 product after reset", prod, 32'h0);

        run_op(16'h0000, 16'h0000, 0);
        run_op(16'h0001, 16'h0001, 0);
        run_op(16'hFFFF, 16'hFFFF, 0);
        run_op(16'hFFFF, 16'h0001, 0);
        run_op(16'h0000, 16'hFFFF, 0);
        run_op(16'h8000, 16'h8000, 0);
        run_op(16'h1234, 16'h00FF, 0);

        // R2 R7: idle with moving operands, product must hold
        held = prod;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); xin = $urandom(); yin = $urandom();
        end
        @(negedge clk);
        check(prod === held, "R7 product held while idle", prod, held);
        check(done === 1'b1, "R2 done while idle", 32'(done), 32'd1);

        // R6: start and operand changes while busy are ignored
        run_op(16'hBEEF, 16'h0F0F, 1);
        run_op(16'hFFFF, 16'h0000, 1);

        for (int k = 0; k < 20; k++) run_op(16'($urandom()), 16'($urandom()), 0);

        // R1: reset in the middle of an operation
        @(negedge clk); xin = 16'h00AA; yin = 16'h0055; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(done === 1'b1, "R1 done after mid-run reset", 32'(done), 32'd1);
        check(prod === 32'h0, "R1 product after mid-run reset", prod, 32'h0);
        run_op(16'h00AA, 16'h0055, 0);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule